// File: doc/BRIEF.md
# Fractional-N Divide Ratio Sequencer

This block produces one integer divide value per reference cycle for the feedback divider of a fractional-N synthesizer. It holds two active 16-bit frequency words, a high one and a low one. Each word has a 4-bit integer field in bits [15:12] and a 12-bit fraction in bits [11:0], in units of 1/4096. The divider ratio a word stands for is its integer field plus a fixed 16, plus the fraction over 4096.

The block picks one active word from the modulation mode and the transmit data bit. A third-order cascade of three first-order accumulators (MASH 1-1-1, 12 bits each) dithers the integer output, so that its long-run mean equals the picked ratio. Software writes new words into staging inputs. The active words change only on a one-cycle load pulse. At that point, out-of-range words are clamped to the legal band, and the modulator state is cleared so that the output sequence restarts in a known way. When the picked fraction is zero, the modulator is held idle and the output is a pure integer divide. The integer nibble of the picked word is reported continuously.

Top module: `fracn_ratio_seq`

## Requirements
- R1: Over the 4096·k cycles that follow a load cycle, with the selection held, the sum of `div_ratio` lies from -1 to +2 away from k·(4096·(I+16)+F). Here I is word bits [15:12] and F is word bits [11:0] of the selected word. In the load cycle itself, `div_ratio` equals I+16.
- R2: With `fsk_mode`=0 the low active word is selected, whatever `tx_bit` is.
- R3: With `fsk_mode`=1, `tx_bit`=1 selects the high active word and `tx_bit`=0 selects the low one. A change of selection shows in `div_ratio` after the next rising clock edge.
- R4: Values on `hi_word_stage`/`lo_word_stage` have no effect on `div_ratio` or `int_nibble` until a clock edge with `load`=1 copies them into the active words.
- R5: Outside a load cycle, each `div_ratio` value lies in I+16-3 .. I+16+4 for the word selected before that edge.
- R6: While the selected fraction is zero, `div_ratio` equals I+16 on every cycle and the modulator state does not advance.
- R7: On load, a staged word below 0x2F42 becomes 0x2F42 and one above 0xC05A becomes 0xC05A. Words inside that range are kept unchanged.
- R8: `int_nibble` equals bits [15:12] of the currently selected active word, without delay.
- R9: After reset, both active words are 0x3B00, `div_ratio` is 19 and `int_nibble` is 3.
- R10: A load clears the modulator, so the same word loaded twice gives the same output sequence, whatever ran before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one output per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_word_stage | input | 16 | Staged high frequency word |
| lo_word_stage | input | 16 | Staged low frequency word |
| load | input | 1 | Copies staged words to active, clears modulator |
| fsk_mode | input | 1 | 0: amplitude keying (low word only), 1: frequency keying |
| tx_bit | input | 1 | Transmit data bit, picks the word in frequency keying |
| div_ratio | output | 6 | Integer divide value for this reference cycle |
| int_nibble | output | 4 | Integer field of the selected active word |

## Verification
The bench loads the boundary words 0x2F42 and 0xC05A, and words far outside them. A missing or one-sided clamp shows as a wrong nibble and a mean ratio far off. Long windows are summed and compared with the exact fraction. A wrong carry-combination sign or a missing accumulator stage then moves the mean or pushes single values out of the -3..+4 band. Zero-fraction words are run for many cycles, where any leaked correction term breaks the constant output. A load repeated after unrelated traffic must reproduce the first sequence, which catches state that survives a load. Staged writes without a load, and `tx_bit` toggling in amplitude mode, must leave the output unchanged.

// File: rtl/fracn_ratio_seq.sv
module fracn_ratio_seq #(
  parameter int INT_W  = 4,
  parameter int FRAC_W = 12,
  parameter int OFFSET = 16,
  parameter logic [INT_W+FRAC_W-1:0] MIN_WORD   = 16'h2F42,
  parameter logic [INT_W+FRAC_W-1:0] MAX_WORD   = 16'hC05A,
  parameter logic [INT_W+FRAC_W-1:0] RESET_WORD = 16'h3B00
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [INT_W+FRAC_W-1:0]  hi_word_stage,
  input  logic [INT_W+FRAC_W-1:0]  lo_word_stage,
  input  logic                     load,
  input  logic                     fsk_mode,
  input  logic                     tx_bit,
  output logic [INT_W+1:0]         div_ratio,
  output logic [INT_W-1:0]         int_nibble
);
  localparam int WORD_W  = INT_W + FRAC_W;
  localparam int RATIO_W = INT_W + 2;

  function automatic logic [WORD_W-1:0] clamp_word(input logic [WORD_W-1:0] w);
    if (w < MIN_WORD)      return MIN_WORD;
    else if (w > MAX_WORD) return MAX_WORD;
    else                   return w;
  endfunction

  logic [WORD_W-1:0] hi_act, lo_act;
  logic [FRAC_W-1:0] acc1, acc2, acc3;
  logic              c2_d, c3_d, c3_dd;

  wire               pick_hi  = fsk_mode && tx_bit;
  wire [WORD_W-1:0]  sel_word = pick_hi ? hi_act : lo_act;
  wire [FRAC_W-1:0]  sel_frac = sel_word[FRAC_W-1:0];
  wire               frac_zero = (sel_frac == '0);
  wire [RATIO_W-1:0] base = RATIO_W'(sel_word[WORD_W-1:FRAC_W]) + RATIO_W'(OFFSET);

  wire [WORD_W-1:0]  ld_hi   = clamp_word(hi_word_stage);
  wire [WORD_W-1:0]  ld_lo   = clamp_word(lo_word_stage);
  wire [WORD_W-1:0]  ld_sel  = pick_hi ? ld_hi : ld_lo;
  wire [RATIO_W-1:0] ld_base = RATIO_W'(ld_sel[WORD_W-1:FRAC_W]) + RATIO_W'(OFFSET);
  wire [RATIO_W-1:0] rst_base = RATIO_W'(RESET_WORD[WORD_W-1:FRAC_W]) + RATIO_W'(OFFSET);

  wire [FRAC_W:0] s1 = {1'b0, acc1} + {1'b0, sel_frac};
  wire [FRAC_W:0] s2 = {1'b0, acc2} + {1'b0, s1[FRAC_W-1:0]};
  wire [FRAC_W:0] s3 = {1'b0, acc3} + {1'b0, s2[FRAC_W-1:0]};
  wire c1 = s1[FRAC_W];
  wire c2 = s2[FRAC_W];
  wire c3 = s3[FRAC_W];

  logic signed [3:0] corr;
  always_comb
    corr = {3'b0, c1} + {3'b0, c2} - {3'b0, c2_d}
         + {3'b0, c3} - {2'b0, c3_d, 1'b0} + {3'b0, c3_dd};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_act <= RESET_WORD;
      lo_act <= RESET_WORD;
      acc1 <= '0; acc2 <= '0; acc3 <= '0;
      c2_d <= 1'b0; c3_d <= 1'b0; c3_dd <= 1'b0;
      div_ratio <= rst_base;
    end else if (load) begin
      hi_act <= ld_hi;
      lo_act <= ld_lo;
      acc1 <= '0; acc2 <= '0; acc3 <= '0;
      c2_d <= 1'b0; c3_d <= 1'b0; c3_dd <= 1'b0;
      div_ratio <= ld_base;
    end else if (frac_zero) begin
      div_ratio <= base;
    end else begin
      acc1 <= s1[FRAC_W-1:0];
      acc2 <= s2[FRAC_W-1:0];
      acc3 <= s3[FRAC_W-1:0];
      c2_d <= c2;
      c3_d <= c3;
      c3_dd <= c3_d;
      div_ratio <= base + RATIO_W'(corr);
    end
  end

  assign int_nibble = sel_word[WORD_W-1:FRAC_W];

  p_band_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !frac_zero) |=> (div_ratio + 3 >= $past(base) && div_ratio <= $past(base) + 4));

  p_int_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && frac_zero) |=> (div_ratio == $past(base) && $stable(acc1) && $stable(acc3)));

  p_stage_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(hi_act) && $stable(lo_act)));

  p_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_act >= MIN_WORD && lo_act <= MAX_WORD && hi_act >= MIN_WORD && hi_act <= MAX_WORD));

  p_load_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc1 == '0 && acc2 == '0 && acc3 == '0 && !c3_d));
endmodule

// File: tb/fracn_ratio_seq_bench.sv
module fracn_ratio_seq_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] hi_stage = 16'h0, lo_stage = 16'h0;
  logic        load = 0, fsk = 0, txb = 0;
  logic [5:0]  ratio;
  logic [3:0]  nib;

  int checks = 0, fails = 0;
  bit done = 0;

  fracn_ratio_seq u_fracn_ratio_seq (
    .clk(clk), .rst_n(rst_n), .hi_word_stage(hi_stage), .lo_word_stage(lo_stage),
    .load(load), .fsk_mode(fsk), .tx_bit(txb), .div_ratio(ratio), .int_nibble(nib));

  always #4 clk = ~clk;

  // {hi, lo, fsk_mode, tx_bit}
  localparam logic [33:0] VECS [7] = '{
    {16'h5000, 16'h3B00, 1'b0, 1'b1},
    {16'h7123, 16'h4555, 1'b1, 1'b1},
    {16'h7123, 16'h4555, 1'b1, 1'b0},
    {16'hC05A, 16'h2F42, 1'b1, 1'b1},
    {16'hFFFF, 16'h0000, 1'b1, 1'b0},
    {16'hFFFF, 16'h0000, 1'b1, 1'b1},
    {16'h9000, 16'h8001, 1'b0, 1'b0}
  };
  localparam int WIN = 8192;

  function automatic logic [15:0] bclamp(input logic [15:0] w);
    if (w < 16'h2F42) return 16'h2F42;
    if (w > 16'hC05A) return 16'hC05A;
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_load(input logic [15:0] h, input logic [15:0] l, input logic f, input logic b);
    hi_stage = h; lo_stage = l; fsk = f; txb = b; load = 1;
    tick();
    load = 0;
  endtask

  int seq_a [32];

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    check(ratio == 6'd19, "R9 reset ratio", ratio, 19);
    check(nib == 4'd3, "R9 reset nibble", nib, 3);

    foreach (VECS[i]) begin
      logic [15:0] h, l, w;
      logic f, b;
      longint sum;
      int bad, eb, ef, dev;
      {h, l, f, b} = VECS[i];
      w = (f && b) ? bclamp(h) : bclamp(l);
      eb = int'(w[15:12]) + 16;
      ef = int'(w[11:0]);
      do_load(h, l, f, b);
      check(nib == w[15:12], "R8/R7 nibble after load", nib, int'(w[15:12]));
      check(int'(ratio) == eb, "R1 load-cycle ratio", ratio, eb);
      sum = 0; bad = 0;
      for (int n = 0; n < WIN; n++) begin
        tick();
        sum += ratio;
        if (int'(ratio) < eb - 3 || int'(ratio) > eb + 4) bad++;
      end
      check(bad == 0, "R5 per-cycle band", bad, 0);
      dev = int'(sum - (longint'(WIN) * eb + (WIN / 4096) * ef));
      check(dev >= -1 && dev <= 2, "R1 window mean", dev, 0);
    end

    // R6: zero fraction gives a constant integer divide
    begin
      int bad = 0;
      do_load(16'h9000, 16'h5000, 1'b0, 1'b0);
      for (int n = 0; n < 300; n++) begin
        tick();
        if (ratio != 6'd21) bad++;
      end
      check(bad == 0, "R6 integer-only constant", bad, 0);
    end

    // R2: tx_bit ignored in amplitude mode
    begin
      int bad = 0;
      for (int n = 0; n < 40; n++) begin
        txb = ~txb;
        tick();
        if (ratio != 6'd21 || nib != 4'd5) bad++;
      end
      check(bad == 0, "R2 tx_bit ignored in ASK", bad, 0);
    end

    // R3: live selection in frequency keying
    fsk = 1; txb = 1;
    #1 check(nib == 4'd9, "R3/R8 nibble high word", nib, 9);
    tick();
    check(ratio == 6'd25, "R3 high word ratio", ratio, 25);
    txb = 0;
    #1 check(nib == 4'd5, "R3/R8 nibble low word", nib, 5);
    tick();
    check(ratio == 6'd21, "R3 low word ratio", ratio, 21);

    // R4: staged values without load have no effect
    begin
      int bad = 0;
      hi_stage = 16'hA800; lo_stage = 16'h7000;
      for (int n = 0; n < 30; n++) begin
        tick();
        if (ratio != 6'd21 || nib != 4'd5) bad++;
      end
      check(bad == 0, "R4 staged words held", bad, 0);
      load = 1; tick(); load = 0;
      check(ratio == 6'd23 && nib == 4'd7, "R4 load applies staged", ratio, 23);
    end

    // R7: clamp of low-side word in ASK
    do_load(16'h0000, 16'h1FFF, 1'b0, 1'b0);
    check(nib == 4'd2, "R7 low clamp nibble", nib, 2);
    check(ratio == 6'd18, "R7 low clamp ratio", ratio, 18);

    // R10: load restarts the sequence
    begin
      int bad = 0;
      do_load(16'h6ABC, 16'h4555, 1'b0, 1'b0);
      for (int n = 0; n < 32; n++) begin tick(); seq_a[n] = int'(ratio); end
      do_load(16'h6ABC, 16'h4555, 1'b1, 1'b1);
      repeat (57) tick();
      do_load(16'h6ABC, 16'h4555, 1'b0, 1'b0);
      for (int n = 0; n < 32; n++) begin
        tick();
        if (int'(ratio) != seq_a[n]) bad++;
      end
      check(bad == 0, "R10 sequence repeats after load", bad, 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule